// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard Controller

This block is the stall and squash control for an in-order pipeline of six stages: fetch, decode, address calculation, operand fetch, execute and write-back. It does not move data. Each instruction is modelled as a small bundle of tags: a valid bit, one destination register, two source registers, a load flag, a branch flag and an execute latency. The controller keeps one bundle per stage and works out every cycle which stages may take new contents, where an empty slot has to be inserted, and when the front end has to be redirected.

The controller handles three hazards. An instruction whose execute latency is longer than one cycle keeps the execute stage occupied, so every stage in front of it is frozen. An instruction in operand fetch that reads the register a load in execute is about to write is held back one cycle, because load data can only be used once the load has reached write-back. When a taken branch completes execute, it cancels the four younger instructions and stops the fetch that is being presented in the same cycle. A free-running cycle counter and a counter of retired instructions sit next to the control logic. Only valid instructions leaving write-back are counted as retired.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is asserted, every stage is empty, both counters read 0, `redirect` is 0 and `fetch_ready` is 1. In every stage vector, bit i stands for stage i+1 (bit 0 is fetch, bit 5 is write-back).
- R2: When no hazard is present, n instructions accepted on consecutive edges retire with the last retirement n+5 edges after the edge that accepted the first one.
- R3: An instruction with execute latency L stays in execute for L cycles. During each of the first L-1 of those cycles, stages 1 to 5 keep their contents, `stage_adv` reads 6'b100000, `stage_bubble` reads 6'b100000 and write-back receives an empty slot.
- R4: A latency field of 0 is treated as 1, and any value above 10 is treated as 10.
- R5: When an instruction in operand fetch has a source equal to the destination of a valid load in execute, it is held for one cycle. During that cycle `stage_adv` reads 6'b110000, `stage_bubble` reads 6'b010000 and execute receives an empty slot.
- R6: Register 0 never creates a load-use dependence.
- R7: A taken branch raises `redirect` during its last execute cycle. In that cycle `fetch_ready` is 0, `stage_adv` reads 6'b111111 and `stage_bubble` reads 6'b011111. On the next cycle stages 1 to 5 are empty, and the four cancelled instructions never retire.
- R8: `branch_taken` has no effect unless execute holds a valid branch that is in its last execute cycle. A branch that is not taken causes no redirect and retires with all instructions behind it.
- R9: The retired counter increases by one exactly on each edge at which write-back holds a valid instruction.
- R10: The cycle counter increases by one on every edge while reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | An instruction bundle is presented at fetch |
| fetch_dst | input | 5 | Destination register tag |
| fetch_src_a | input | 5 | First source register tag |
| fetch_src_b | input | 5 | Second source register tag |
| fetch_is_load | input | 1 | Instruction is a load |
| fetch_is_branch | input | 1 | Instruction is a branch |
| fetch_lat | input | 4 | Execute latency in cycles (1 to 10) |
| branch_taken | input | 1 | Outcome of the branch currently in execute |
| fetch_ready | output | 1 | The presented bundle is taken on this edge |
| stage_adv | output | 6 | Per-stage load enable for this edge |
| stage_bubble | output | 6 | Stage receives an inserted empty slot on this edge |
| stage_valid | output | 6 | Stage currently holds a valid instruction |
| redirect | output | 1 | Front end must restart at the branch target |
| cycle_count | output | 32 | Cycles since reset |
| retired_count | output | 32 | Valid instructions that have left write-back |

## Verification
The bound checker checks on every cycle the properties that hold at any moment. Both counters must step correctly. A redirect must block fetch and must leave stages 1 to 5 empty on the next cycle. A frozen execute stage must keep the valid bits of stages 1 to 5 unchanged. An inserted bubble must actually arrive empty in its stage. Some results depend on a whole sequence of instructions: total completion spans for mixed latencies and load-use pairs, the latency clamp, the register 0 exemption, and the fact that cancelled instructions never retire. Only the bench scenarios show these, by counting edges from the first acceptance to the last retirement and by watching the retired counter.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;

    localparam int unsigned NSTAGE   = 6;
    localparam int unsigned TAG_W    = 5;
    localparam int unsigned LAT_W    = 4;
    localparam int unsigned LAT_MAX  = 10;
    localparam int unsigned OPND_IDX = 3;
    localparam int unsigned EX_IDX   = 4;
    localparam int unsigned WB_IDX   = 5;

    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);
    localparam logic [LAT_W-1:0] LAT_CAP = LAT_W'(LAT_MAX);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] dst;
        logic [TAG_W-1:0] src_a;
        logic [TAG_W-1:0] src_b;
        logic             ld;
        logic             br;
        logic [LAT_W-1:0] lat;
    } slot_t;

    function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] raw);
        if (raw == '0)
            return LAT_ONE;
        if (raw > LAT_CAP)
            return LAT_CAP;
        return raw;
    endfunction

endpackage

// File: rtl/hz_detect.sv
module hz_detect
    import pipe_hz_pkg::*;
(
    input  slot_t opnd_i,
    input  slot_t ex_i,
    input  logic  ex_busy_i,
    input  logic  br_taken_i,
    output logic  stall_ex_o,
    output logic  stall_lu_o,
    output logic  flush_o
);

    logic dst_live;
    logic src_hit;

    always_comb begin
        // register 0 is never a real producer
        dst_live   = ex_i.vld && ex_i.ld && (ex_i.dst != '0);
        src_hit    = (opnd_i.src_a == ex_i.dst) || (opnd_i.src_b == ex_i.dst);
        stall_ex_o = ex_i.vld && ex_busy_i;
        flush_o    = ex_i.vld && ex_i.br && br_taken_i && !ex_busy_i;
        // a flush outranks the load-use interlock
        stall_lu_o = opnd_i.vld && dst_live && src_hit && !stall_ex_o && !flush_o;
    end

endmodule

// File: rtl/hz_busy.sv
module hz_busy
    import pipe_hz_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  slot_t slot_i,
    output logic  busy_o
);

    logic [LAT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = slot_i.vld ? (clamp_lat(slot_i.lat) - LAT_ONE) : '0;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - LAT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/hz_count.sv
module hz_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    output logic [CNT_W-1:0] cycle_o,
    output logic [CNT_W-1:0] retired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] ret;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        cnt_d.cyc = cnt_q.cyc + {{(CNT_W-1){1'b0}}, 1'b1};
        cnt_d.ret = cnt_q.ret + {{(CNT_W-1){1'b0}}, retire_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cycle_o   = cnt_q.cyc;
    assign retired_o = cnt_q.ret;

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import pipe_hz_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fetch_valid,
    input  logic [TAG_W-1:0]       fetch_dst,
    input  logic [TAG_W-1:0]       fetch_src_a,
    input  logic [TAG_W-1:0]       fetch_src_b,
    input  logic                   fetch_is_load,
    input  logic                   fetch_is_branch,
    input  logic [LAT_W-1:0]       fetch_lat,
    input  logic                   branch_taken,
    output logic                   fetch_ready,
    output logic [NSTAGE-1:0]      stage_adv,
    output logic [NSTAGE-1:0]      stage_bubble,
    output logic [NSTAGE-1:0]      stage_valid,
    output logic                   redirect,
    output logic [CNT_W-1:0]       cycle_count,
    output logic [CNT_W-1:0]       retired_count
);

    slot_t stg_d [NSTAGE];
    slot_t stg_q [NSTAGE];
    slot_t fetch_slot;

    logic ex_busy;
    logic stall_ex;
    logic stall_lu;
    logic flush;

    logic [NSTAGE-1:0] hold;
    logic [NSTAGE-1:0] en;
    logic [NSTAGE-1:0] bub;

    hz_detect u_detect (
        .opnd_i     (stg_q[OPND_IDX]),
        .ex_i       (stg_q[EX_IDX]),
        .ex_busy_i  (ex_busy),
        .br_taken_i (branch_taken),
        .stall_ex_o (stall_ex),
        .stall_lu_o (stall_lu),
        .flush_o    (flush)
    );

    hz_busy u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (en[EX_IDX]),
        .slot_i (stg_d[EX_IDX]),
        .busy_o (ex_busy)
    );

    hz_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (stg_q[WB_IDX].vld),
        .cycle_o   (cycle_count),
        .retired_o (retired_count)
    );

    // per-stage freeze, enable and bubble control
    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        localparam bit UP_EX = (g <= EX_IDX);
        localparam bit UP_OP = (g <= OPND_IDX);

        assign hold[g] = (stall_ex & UP_EX) | (stall_lu & UP_OP);
        assign en[g]   = ~hold[g];

        if (g == 0) begin : g_head
            assign bub[g] = flush;
        end else begin : g_tail
            assign bub[g] = en[g] & (hold[g-1] | (flush & UP_EX));
        end

        assign stage_valid[g] = stg_q[g].vld;
    end

    always_comb begin
        fetch_slot       = '0;
        fetch_slot.vld   = fetch_valid;
        fetch_slot.dst   = fetch_dst;
        fetch_slot.src_a = fetch_src_a;
        fetch_slot.src_b = fetch_src_b;
        fetch_slot.ld    = fetch_is_load;
        fetch_slot.br    = fetch_is_branch;
        fetch_slot.lat   = fetch_lat;

        stg_d[0] = stg_q[0];
        if (en[0])
            stg_d[0] = bub[0] ? '0 : fetch_slot;

        for (int i = 1; i < NSTAGE; i++) begin
            stg_d[i] = stg_q[i];
            if (en[i])
                stg_d[i] = bub[i] ? '0 : stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTAGE; i++)
                stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSTAGE; i++)
                stg_q[i] <= stg_d[i];
        end
    end

    assign fetch_ready  = en[0] & ~flush;
    assign stage_adv    = en;
    assign stage_bubble = bub;
    assign redirect     = flush;

endmodule

// File: rtl/hz_check.sv
module hz_check
    import pipe_hz_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_ready,
    input logic [NSTAGE-1:0] stage_adv,
    input logic [NSTAGE-1:0] stage_bubble,
    input logic [NSTAGE-1:0] stage_valid,
    input logic              redirect,
    input logic [CNT_W-1:0]  cycle_count,
    input logic [CNT_W-1:0]  retired_count
);

    assert_cycle_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_count == $past(cycle_count) + {{(CNT_W-1){1'b0}}, 1'b1});

    assert_retire_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> retired_count == $past(retired_count) + {{(CNT_W-1){1'b0}}, $past(stage_valid[WB_IDX])});

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> stage_valid[EX_IDX:0] == '0);

    assert_flush_blocks_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !fetch_ready);

    assert_ex_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_adv[EX_IDX] |=> $stable(stage_valid[EX_IDX:0]));

    assert_wb_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stage_bubble[WB_IDX] |=> !stage_valid[WB_IDX]);

    assert_ex_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_bubble[EX_IDX] |=> !stage_valid[EX_IDX]);

endmodule

bind pipe_hazard_ctrl hz_check #(.CNT_W(CNT_W)) u_hz_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_ready   (fetch_ready),
    .stage_adv     (stage_adv),
    .stage_bubble  (stage_bubble),
    .stage_valid   (stage_valid),
    .redirect      (redirect),
    .cycle_count   (cycle_count),
    .retired_count (retired_count)
);

// File: tb/test_pipe_hazard_ctrl.sv
`timescale 1ns/1ps
module test_pipe_hazard_ctrl;

    localparam int CNT_W = 32;
    localparam int EDGE_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [4:0]  fetch_dst = '0, fetch_src_a = '0, fetch_src_b = '0;
    logic        fetch_is_load = 1'b0, fetch_is_branch = 1'b0;
    logic [3:0]  fetch_lat = 4'd1;
    logic        branch_taken = 1'b0;
    logic        fetch_ready, redirect;
    logic [5:0]  stage_adv, stage_bubble, stage_valid;
    logic [CNT_W-1:0] cycle_count, retired_count;

    pipe_hazard_ctrl #(.CNT_W(CNT_W)) i_pipe_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid),
        .fetch_dst(fetch_dst), .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b),
        .fetch_is_load(fetch_is_load), .fetch_is_branch(fetch_is_branch),
        .fetch_lat(fetch_lat), .branch_taken(branch_taken),
        .fetch_ready(fetch_ready), .stage_adv(stage_adv), .stage_bubble(stage_bubble),
        .stage_valid(stage_valid), .redirect(redirect),
        .cycle_count(cycle_count), .retired_count(retired_count)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    always @(posedge clk) begin
        edges = edges + 1;
        if (!done && edges > EDGE_LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d edges, expected fewer than %0d", edges, EDGE_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // n, latency, load-use pairs, register 0 tags, expected span in edges
    typedef struct packed {
        logic [7:0] n;
        logic [7:0] lat;
        logic       dep;
        logic       rz;
        logic [7:0] span;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd1, 8'd1,  1'b0, 1'b0, 8'd6},
        '{8'd8, 8'd1,  1'b0, 1'b0, 8'd13},
        '{8'd3, 8'd4,  1'b0, 1'b0, 8'd17},
        '{8'd2, 8'd10, 1'b0, 1'b0, 8'd25},
        '{8'd4, 8'd1,  1'b1, 1'b0, 8'd11},
        '{8'd6, 8'd2,  1'b0, 1'b0, 8'd17},
        '{8'd4, 8'd1,  1'b1, 1'b1, 8'd9},
        '{8'd4, 8'd2,  1'b1, 1'b0, 8'd15},
        '{8'd1, 8'd15, 1'b0, 1'b0, 8'd15},
        '{8'd1, 8'd0,  1'b0, 1'b0, 8'd6}
    };

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // present one bundle, return after the edge that takes it
    task automatic put(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                       input logic ld, input logic br, input logic [3:0] lat,
                       output int acc);
        fetch_valid     = 1'b1;
        fetch_dst       = d;
        fetch_src_a     = a;
        fetch_src_b     = b;
        fetch_is_load   = ld;
        fetch_is_branch = br;
        fetch_lat       = lat;
        while (!fetch_ready) @(negedge clk);
        acc = edges + 1;
        @(negedge clk);
    endtask

    task automatic drain(input int c);
        fetch_valid     = 1'b0;
        fetch_is_branch = 1'b0;
        fetch_is_load   = 1'b0;
        repeat (c) @(negedge clk);
    endtask

    // branch followed by wrong-path fetches; returns after the branch's acceptance
    task automatic branch_start(input logic [3:0] lat, input logic taken);
        int acc;
        branch_taken = taken;
        put(5'd8, 5'd1, 5'd2, 1'b0, 1'b1, lat, acc);
        fetch_valid     = 1'b1;
        fetch_is_branch = 1'b0;
        fetch_dst       = 5'd9;
        fetch_src_a     = 5'd10;
        fetch_src_b     = 5'd11;
        fetch_lat       = 4'd1;
    endtask

    initial begin
        int acc, first, base, tmo;
        longint c0;
        string tag;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 stage_valid in reset", stage_valid, 0);
        check_eq("R1 cycle_count in reset", cycle_count, 0);
        check_eq("R1 retired_count in reset", retired_count, 0);
        check_eq("R1 redirect in reset", redirect, 0);
        check_eq("R1 fetch_ready in reset", fetch_ready, 1);
        rst_n = 1'b1;

        // R10: cycle counter
        @(negedge clk);
        c0 = cycle_count;
        repeat (5) @(negedge clk);
        check_eq("R10 cycle count step", cycle_count, c0 + 5);

        // vector table: completion spans
        for (int v = 0; v < 10; v++) begin
            base  = retired_count;
            first = 0;
            for (int k = 0; k < VECS[v].n; k++) begin
                logic [4:0] d, a, b;
                logic ld;
                logic [4:0] p;
                p = VECS[v].rz ? 5'd0 : 5'd3;
                if (VECS[v].dep && (k % 2 == 0)) begin
                    ld = 1'b1; d = p; a = 5'd1; b = 5'd2;
                end else if (VECS[v].dep) begin
                    ld = 1'b0; d = 5'd6;
                    a = (k % 4 == 1) ? p : 5'd5;
                    b = (k % 4 == 1) ? 5'd5 : p;
                end else begin
                    ld = 1'b0; d = 5'(1 + k % 7); a = 5'd2; b = 5'd4;
                end
                put(d, a, b, ld, 1'b0, VECS[v].lat[3:0], acc);
                if (k == 0) first = acc;
            end
            fetch_valid = 1'b0;
            tmo = 0;
            while (retired_count != CNT_W'(base + VECS[v].n) && tmo < 300) begin
                @(negedge clk);
                tmo++;
            end
            if (VECS[v].rz)                                   tag = "R6 register 0 span";
            else if (VECS[v].dep)                             tag = "R5 load-use span";
            else if (VECS[v].lat == 0 || VECS[v].lat > 10)    tag = "R4 latency clamp span";
            else if (VECS[v].lat > 1)                         tag = "R3 multi-cycle span";
            else                                              tag = "R2 hazard-free span";
            check_eq(tag, edges - first, VECS[v].span);
            drain(4);
            check_eq("R9 retired delta", retired_count - base, VECS[v].n);
        end

        // R5: enable and bubble pattern during load-use hold
        drain(12);
        put(5'd3, 5'd1, 5'd2, 1'b1, 1'b0, 4'd1, acc);
        put(5'd6, 5'd3, 5'd5, 1'b0, 1'b0, 4'd1, acc);
        fetch_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R5 stage_adv during hold", stage_adv, 6'b110000);
        check_eq("R5 stage_bubble during hold", stage_bubble, 6'b010000);
        @(negedge clk);
        check_eq("R5 stage_adv after hold", stage_adv, 6'b111111);
        check_eq("R5 stage_bubble after hold", stage_bubble, 6'b000000);

        // R3: enable and bubble pattern during execute occupancy
        drain(12);
        put(5'd7, 5'd1, 5'd2, 1'b0, 1'b0, 4'd4, acc);
        fetch_valid = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R3 stage_adv while busy", stage_adv, 6'b100000);
        check_eq("R3 stage_bubble while busy", stage_bubble, 6'b100000);
        repeat (3) @(negedge clk);
        check_eq("R3 stage_adv last cycle", stage_adv, 6'b111111);

        // R7: taken branch, single-cycle execute
        drain(12);
        base = retired_count;
        branch_start(4'd1, 1'b1);
        repeat (4) @(negedge clk);
        check_eq("R7 redirect", redirect, 1);
        check_eq("R7 fetch_ready during redirect", fetch_ready, 0);
        check_eq("R7 stage_valid at redirect", stage_valid, 6'b011111);
        check_eq("R7 stage_adv at redirect", stage_adv, 6'b111111);
        check_eq("R7 stage_bubble at redirect", stage_bubble, 6'b011111);
        @(negedge clk);
        fetch_valid = 1'b0;
        check_eq("R7 stage_valid after redirect", stage_valid, 6'b100000);
        drain(12);
        check_eq("R7 squashed never retire", retired_count - base, 1);

        // R7: taken branch with three-cycle execute resolves late
        base = retired_count;
        branch_start(4'd3, 1'b1);
        repeat (4) @(negedge clk);
        check_eq("R7 no redirect while busy (1)", redirect, 0);
        @(negedge clk);
        check_eq("R7 no redirect while busy (2)", redirect, 0);
        @(negedge clk);
        check_eq("R7 late redirect", redirect, 1);
        check_eq("R7 late stage_valid", stage_valid, 6'b011111);
        drain(14);
        check_eq("R7 late squash retire", retired_count - base, 1);

        // R8: branch not taken
        base = retired_count;
        branch_start(4'd1, 1'b0);
        repeat (4) @(negedge clk);
        check_eq("R8 no redirect when not taken", redirect, 0);
        check_eq("R8 stage_valid not taken", stage_valid, 6'b011111);
        drain(14);
        check_eq("R8 all retire when not taken", retired_count - base, 5);

        // R8: branch_taken with a non-branch in execute
        base = retired_count;
        branch_taken = 1'b1;
        put(5'd4, 5'd1, 5'd2, 1'b0, 1'b0, 4'd1, acc);
        fetch_valid = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R8 taken flag ignored for non-branch", redirect, 0);
        drain(10);
        branch_taken = 1'b0;
        check_eq("R8 non-branch retires", retired_count - base, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule